// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Sequential Prefetch Buffer

This block is a read-only, direct-mapped line cache. A small sequential prefetch buffer sits beside it. The processor side presents one byte address at a time and gets back the addressed word. The memory side receives whole-line fill requests and returns whole lines after any number of cycles. When a request misses, the block fetches the line into its set. It also queues the next two sequential lines into the prefetch buffer.

The prefetch buffer is a FIFO, and only its oldest entry is compared with a request. When that entry matches, the access is a buffer hit:
- the line is copied into its cache set,
- the entry is retired,
- the line after the youngest entry is queued.

A request that matches neither the cache nor the buffer head discards all buffer contents. Prefetching then starts again from the missed line plus one.

Three saturating counters report the results:
- cache hits,
- buffer hits,
- full misses.

With these, the miss rate of an address stream can be read at the ports.

Processor-side back-pressure works as follows:
- `req_ready` is high only while no request is being served, so one request is handled at a time.
- `rsp_valid` with `rsp_data` stays asserted and unchanged until `rsp_ready` is sampled high.

Memory-side back-pressure works as follows:
- `mem_req_valid` with `mem_req_line` is held unchanged until `mem_req_ready` is sampled high.
- At most one memory request is open at a time.
- The fill return has no ready, because the block always has a place for the returning line.

Top module: `seqpf_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and all three counters are 0.
- R2: A request whose line is present in its set returns the addressed 32-bit word (word select = byte address bits [4:2] for 32-byte lines) and increments `cnt_hit` by one.
- R3: A request matching neither the cache nor the buffer head increments `cnt_miss`. It issues a fill for line address = byte address >> 5, installs the returned line in set (line address mod 2048), and returns the addressed word.
- R4: After a miss on line L, lines L+1 and L+2 are requested into the buffer. For a purely sequential word stream over N lines, this gives exactly 1 miss, N-1 buffer hits and 7N cache hits.
- R5: A buffer hit counts in `cnt_sbhit`, installs the line in the cache so that a later access to it is a cache hit, and queues the next sequential line.
- R6: Only the buffer head is compared. A request for a line held in a non-head buffer entry is a miss. That miss discards the buffer, and a following access to the missed line plus one is a buffer hit.
- R7: Two lines with the same set index but different tags evict each other, so alternating between them misses every time.
- R8: Every line is requested from memory at most once during a sequential stream. A buffer line whose fill is still outstanding is waited for, not requested again. At most one memory request is open at any time.
- R9: After a miss, the demand fill is the next request issued to memory, ahead of any queued prefetch. A presented memory request keeps its line address stable until accepted.
- R10: While a response waits for `rsp_ready`, `rsp_valid` stays 1, `rsp_data` stays stable and `req_ready` stays 0.
- R11: Each counter saturates at its all-ones value and stays there. Other counters are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Processor accepts read data |
| rsp_data | output | 32 | Addressed word |
| mem_req_valid | output | 1 | Line fill request valid |
| mem_req_ready | input | 1 | Memory accepts the fill request |
| mem_req_line | output | ADDR_W-5 | Line address to fetch |
| mem_rsp_valid | input | 1 | Returned line valid (one cycle) |
| mem_rsp_data | input | 256 | Returned line, word 0 in the low bits |
| cnt_hit | output | CNT_W | Saturating cache-hit count |
| cnt_sbhit | output | CNT_W | Saturating buffer-hit count |
| cnt_miss | output | CNT_W | Saturating miss count |

## Verification
The bench reads a sequential word stream through a slow, stalling memory. It checks the exact split of misses, buffer hits and cache hits. A design that re-requested a prefetch still in flight would show duplicate lines in the memory log. A design that promoted lines wrongly would return wrong words at line boundaries.

It then requests a line sitting in the second buffer entry. A design that compared every entry would count a buffer hit where a miss is required. A design that did not restart prefetching would miss on the following line. The same step checks that the demand fill reaches memory first.

Further steps cover:
- conflicting tags in one set;
- a response held under back-pressure;
- counter saturation under a long run of hits.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;

  // state of one prefetch buffer slot
  typedef enum logic [1:0] {
    SB_EMPTY = 2'd0,
    SB_PEND  = 2'd1,  // allocated, request not yet sent
    SB_INFL  = 2'd2,  // request sent, line not back
    SB_FULL  = 2'd3   // line present
  } sb_st_e;

  // request controller state
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOOK = 3'd1,
    ST_FILL = 3'd2,
    ST_WAIT = 3'd3,
    ST_RESP = 3'd4
  } ctl_st_e;

endpackage

// File: rtl/seqpf_line_store.sv
module seqpf_line_store #(
  parameter int SETS   = 2048,
  parameter int TAG_W  = 16,
  parameter int LINE_W = 256,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data
);

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  // R3: an installed line marks its set as holding data
  p_fill_marks_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/seqpf_stream_buf.sv
module seqpf_stream_buf
  import seqpf_pkg::*;
#(
  parameter int DEPTH   = 2,
  parameter int LADDR_W = 27,
  parameter int LINE_W  = 256,
  localparam int IW     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [LADDR_W-1:0] flush_base,
  input  logic               pop,
  input  logic               issue,
  input  logic               fill,
  input  logic [LINE_W-1:0]  fill_data,
  output logic [LADDR_W-1:0] head_line,
  output sb_st_e             head_st,
  output logic [LINE_W-1:0]  head_data,
  output logic               pend_any,
  output logic [LADDR_W-1:0] pend_line
);

  logic [LADDR_W-1:0] line_q [DEPTH];
  sb_st_e             st_q   [DEPTH];
  logic [LINE_W-1:0]  data_q [DEPTH];
  logic [LADDR_W-1:0] line_d [DEPTH];
  sb_st_e             st_d   [DEPTH];
  logic [LINE_W-1:0]  data_d [DEPTH];
  logic [IW-1:0]      pend_idx;
  logic [DEPTH-1:0]   infl_v;

  // oldest slot still waiting for its request
  always_comb begin
    pend_any = 1'b0;
    pend_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (st_q[i] == SB_PEND) begin
        pend_any = 1'b1;
        pend_idx = IW'(i);
      end
    end
    for (int i = 0; i < DEPTH; i++) infl_v[i] = (st_q[i] == SB_INFL);
  end

  assign pend_line = line_q[pend_idx];
  assign head_line = line_q[0];
  assign head_st   = st_q[0];
  assign head_data = data_q[0];

  // order: fill, issue, then retire/flush
  always_comb begin
    line_d = line_q;
    st_d   = st_q;
    data_d = data_q;
    if (fill) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (st_q[i] == SB_INFL) begin
          st_d[i]   = SB_FULL;
          data_d[i] = fill_data;
        end
      end
    end
    if (issue && pend_any) st_d[pend_idx] = SB_INFL;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        line_d[i] = line_d[i+1];
        st_d[i]   = st_d[i+1];
        data_d[i] = data_d[i+1];
      end
      line_d[DEPTH-1] = line_q[DEPTH-1] + LADDR_W'(1);
      st_d[DEPTH-1]   = SB_PEND;
    end
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) begin
        line_d[i] = flush_base + LADDR_W'(i + 1);
        st_d[i]   = SB_PEND;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i] <= '0;
        st_q[i]   <= SB_EMPTY;
        data_q[i] <= '0;
      end
    end else begin
      line_q <= line_d;
      st_q   <= st_d;
      data_q <= data_d;
    end
  end

  // R8: never more than one slot awaiting memory
  p_single_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(infl_v));

  // R6: a discard restarts the head at the missed line plus one
  p_flush_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (st_q[0] == SB_PEND && line_q[0] == $past(flush_base) + LADDR_W'(1)));

endmodule

// File: rtl/seqpf_sat_cnt.sv
module seqpf_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (!rst_n)                   value <= '0;
    else if (inc && value != '1)  value <= value + W'(1);
  end

  // R11: an all-ones count never moves again
  p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (value == '1) |=> (value == '1));

  // R11: below the ceiling every event adds exactly one
  p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && value != '1) |=> (value == $past(value) + W'(1)));

endmodule

// File: rtl/seqpf_cache.sv
module seqpf_cache
  import seqpf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 65536,
  parameter int LINE_BYTES  = 32,
  parameter int WORD_BYTES  = 4,
  parameter int SB_DEPTH    = 2,
  parameter int CNT_W       = 16,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int WORD_W  = WORD_BYTES * 8,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WORD_W-1:0]  rsp_data,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [LADDR_W-1:0] mem_req_line,
  input  logic               mem_rsp_valid,
  input  logic [LINE_W-1:0]  mem_rsp_data,
  output logic [CNT_W-1:0]   cnt_hit,
  output logic [CNT_W-1:0]   cnt_sbhit,
  output logic [CNT_W-1:0]   cnt_miss
);

  localparam int SETS   = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = LADDR_W - IDX_W;
  localparam int WOFF_W = $clog2(WORD_BYTES);
  localparam int NCNT   = 3;

  ctl_st_e            state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LINE_W-1:0]  rsp_line_q;
  logic               mreq_v_q, mreq_dem_q, infl_q, infl_dem_q;
  logic [LADDR_W-1:0] mreq_line_q;

  logic [LADDR_W-1:0] req_line;
  logic [IDX_W-1:0]   req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic [OFF_W-WOFF_W-1:0] wsel;
  logic               unused_lo;

  assign req_line  = addr_q[ADDR_W-1:OFF_W];
  assign req_idx   = req_line[IDX_W-1:0];
  assign req_tag   = req_line[LADDR_W-1:IDX_W];
  assign wsel      = addr_q[OFF_W-1:WOFF_W];
  assign unused_lo = ^addr_q[WOFF_W-1:0];

  // cache lookup
  logic              st_valid;
  logic [TAG_W-1:0]  st_tag;
  logic [LINE_W-1:0] st_data;
  logic              wr_en;
  logic [LINE_W-1:0] wr_data;

  // prefetch buffer
  logic [LADDR_W-1:0] sb_head_line, sb_pend_line;
  sb_st_e             sb_head_st;
  logic [LINE_W-1:0]  sb_head_data;
  logic               sb_pend_any;

  logic cache_hit, sb_match, sb_hit, miss_now;
  logic mem_idle, sel_dem, sel_pf, dem_rsp, pf_rsp;

  always_comb begin
    cache_hit = (state_q == ST_LOOK) && st_valid && (st_tag == req_tag);
    sb_match  = (sb_head_st != SB_EMPTY) && (sb_head_line == req_line);
    sb_hit    = (state_q == ST_LOOK) && !cache_hit && sb_match && (sb_head_st == SB_FULL);
    miss_now  = (state_q == ST_LOOK) && !cache_hit && !sb_match;
    mem_idle  = !mreq_v_q && !infl_q;
    // demand fill wins over every queued prefetch
    sel_dem   = (state_q == ST_FILL) && mem_idle;
    sel_pf    = mem_idle && sb_pend_any && !miss_now && (state_q != ST_FILL);
    dem_rsp   = mem_rsp_valid && infl_q && infl_dem_q;
    pf_rsp    = mem_rsp_valid && infl_q && !infl_dem_q;
    wr_en     = sb_hit || dem_rsp;
    wr_data   = sb_hit ? sb_head_data : mem_rsp_data;
  end

  seqpf_line_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_valid (st_valid),
    .rd_tag   (st_tag),
    .rd_data  (st_data),
    .wr_en    (wr_en),
    .wr_idx   (req_idx),
    .wr_tag   (req_tag),
    .wr_data  (wr_data)
  );

  seqpf_stream_buf #(.DEPTH(SB_DEPTH), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_sbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (miss_now),
    .flush_base (req_line),
    .pop        (sb_hit),
    .issue      (sel_pf),
    .fill       (pf_rsp),
    .fill_data  (mem_rsp_data),
    .head_line  (sb_head_line),
    .head_st    (sb_head_st),
    .head_data  (sb_head_data),
    .pend_any   (sb_pend_any),
    .pend_line  (sb_pend_line)
  );

  // event counters: hit, buffer hit, miss
  logic [NCNT-1:0]  inc_v;
  logic [CNT_W-1:0] cnt_v [NCNT];
  assign inc_v = {miss_now, sb_hit, cache_hit};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    seqpf_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_v[g]),
      .value (cnt_v[g])
    );
  end

  assign cnt_hit   = cnt_v[0];
  assign cnt_sbhit = cnt_v[1];
  assign cnt_miss  = cnt_v[2];

  // memory request channel, one transaction at a time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mreq_v_q    <= 1'b0;
      mreq_dem_q  <= 1'b0;
      mreq_line_q <= '0;
      infl_q      <= 1'b0;
      infl_dem_q  <= 1'b0;
    end else begin
      if (sel_dem || sel_pf) begin
        mreq_v_q    <= 1'b1;
        mreq_dem_q  <= sel_dem;
        mreq_line_q <= sel_dem ? req_line : sb_pend_line;
      end else if (mreq_v_q && mem_req_ready) begin
        mreq_v_q   <= 1'b0;
        infl_q     <= 1'b1;
        infl_dem_q <= mreq_dem_q;
      end
      if (mem_rsp_valid) infl_q <= 1'b0;
    end
  end

  // request controller
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      rsp_line_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (cache_hit) begin
            rsp_line_q <= st_data;
            state_q    <= ST_RESP;
          end else if (sb_hit) begin
            rsp_line_q <= sb_head_data;
            state_q    <= ST_RESP;
          end else if (miss_now) begin
            state_q <= ST_FILL;
          end
        end
        ST_FILL: if (sel_dem) state_q <= ST_WAIT;
        ST_WAIT: if (dem_rsp) begin
          rsp_line_q <= mem_rsp_data;
          state_q    <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_data      = rsp_line_q[wsel*WORD_W +: WORD_W];
  assign mem_req_valid = mreq_v_q;
  assign mem_req_line  = mreq_line_q;

  // R10: a pending response holds its data
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9: a presented memory request is not withdrawn or altered
  p_memreq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_line)));

  // R9: once the channel frees up during a miss, the demand line goes out first
  p_demand_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && !mem_req_valid && !infl_q) |=>
      (mem_req_valid && mem_req_line == $past(req_line)));

  // R8: memory only returns lines that were asked for
  p_no_stray_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> infl_q);

endmodule

// File: tb/seqpf_cache_tb.sv
module seqpf_cache_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int LINE_W     = 256;
  localparam int WORD_W     = 32;
  localparam int LADDR_W    = 27;
  localparam int CNT_W      = 8;
  localparam int CMAX       = 255;

  logic               clk, rst_n;
  logic               req_valid, req_ready;
  logic [ADDR_W-1:0]  req_addr;
  logic               rsp_valid, rsp_ready;
  logic [WORD_W-1:0]  rsp_data;
  logic               mem_req_valid, mem_req_ready;
  logic [LADDR_W-1:0] mem_req_line;
  logic               mem_rsp_valid;
  logic [LINE_W-1:0]  mem_rsp_data;
  logic [CNT_W-1:0]   cnt_hit, cnt_sbhit, cnt_miss;

  seqpf_cache #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cnt_hit(cnt_hit), .cnt_sbhit(cnt_sbhit), .cnt_miss(cnt_miss)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int mem_lat = 6;
  int unsigned cyc = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int unsigned mlog  [$];

  function automatic logic [31:0] word_of(input longint unsigned widx);
    return 32'(widx * 64'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [LINE_W-1:0] line_of(input logic [LADDR_W-1:0] l);
    logic [LINE_W-1:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = word_of(longint'(l) * 8 + w);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory: stalls one cycle in three, fixed latency per response
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_req_ready = (cyc % 3) != 2;

  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid && mem_req_ready) begin
        logic [LADDR_W-1:0] l;
        l = mem_req_line;
        mlog.push_back(int'(l));
        @(posedge clk);
        repeat (mem_lat - 1) @(posedge clk);
        #1;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = line_of(l);
        @(posedge clk);
        #1;
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected response", rsp_data, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic issue(input logic [31:0] a, input string tag);
    req_addr  = a;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    exp_q.push_back(word_of(longint'(a >> 2)));
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic read(input logic [31:0] a, input string tag);
    issue(a, tag);
    drain();
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  int e_hit = 0, e_sb = 0, e_miss = 0;

  initial begin
    int n0;
    int dups;
    logic [31:0] held;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    rsp_ready = 1'b1;
    idle(3);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", mem_req_valid, 0);
    check(cnt_hit == 0 && cnt_sbhit == 0, "R1 hit counters after reset", cnt_hit + cnt_sbhit, 0);
    check(cnt_miss == 0, "R1 miss counter after reset", cnt_miss, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(2);

    // sequential stream over four lines
    for (int w = 0; w < 32; w++) begin
      if (w == 0) begin
        read(32'(w * 4), "R3 miss data");
        e_miss++;
      end else if (w % 8 == 0) begin
        read(32'(w * 4), "R4 buffer hit data");
        e_sb++;
      end else begin
        read(32'(w * 4), "R2 cache hit data");
        e_hit++;
      end
    end
    idle(40);
    check(cnt_miss == CNT_W'(e_miss), "R4 stream misses", cnt_miss, e_miss);
    check(cnt_sbhit == CNT_W'(e_sb), "R4 stream buffer hits", cnt_sbhit, e_sb);
    check(cnt_hit == CNT_W'(e_hit), "R2 stream cache hits", cnt_hit, e_hit);
    check(mlog.size() == 6, "R8 stream fill count", mlog.size(), 6);
    check(mlog.size() > 0 && mlog[0] == 0, "R3 first fill line", mlog.size() > 0 ? mlog[0] : -1, 0);
    dups = 0;
    for (int i = 0; i < mlog.size(); i++)
      for (int j = i + 1; j < mlog.size(); j++)
        if (mlog[i] == mlog[j]) dups++;
    check(dups == 0, "R8 duplicate line requests", dups, 0);

    // promoted line now lives in the cache
    read(32'h40, "R5 promoted line data");
    e_hit++;
    check(cnt_hit == CNT_W'(e_hit), "R5 promoted line is cache hit", cnt_hit, e_hit);
    check(cnt_sbhit == CNT_W'(e_sb), "R5 no extra buffer hit", cnt_sbhit, e_sb);

    // buffer holds lines 4 (head) and 5; line 5 must miss
    n0 = mlog.size();
    read(32'hA0, "R6 non-head line data");
    e_miss++;
    check(cnt_miss == CNT_W'(e_miss), "R6 non-head entry is a miss", cnt_miss, e_miss);
    check(mlog.size() > n0 && mlog[n0] == 5, "R9 demand fill goes first",
          mlog.size() > n0 ? mlog[n0] : -1, 5);
    idle(40);
    check(mlog.size() > n0 + 2 && mlog[n0+1] == 6 && mlog[n0+2] == 7, "R6 prefetch restart lines",
          mlog.size() > n0 + 1 ? mlog[n0+1] : -1, 6);
    read(32'hC0, "R6 restarted line data");
    e_sb++;
    check(cnt_sbhit == CNT_W'(e_sb), "R6 restarted line is buffer hit", cnt_sbhit, e_sb);

    // set conflict: line 0x801 and line 1 share set 1
    read(32'h0001_0020, "R7 conflicting line data");
    e_miss++;
    read(32'h20, "R7 evicted line data");
    e_miss++;
    check(cnt_miss == CNT_W'(e_miss), "R7 conflict misses", cnt_miss, e_miss);
    read(32'h24, "R7 refilled line data");
    e_hit++;
    check(cnt_hit == CNT_W'(e_hit), "R7 refilled line hits", cnt_hit, e_hit);

    // back-pressure on the response
    rsp_ready = 1'b0;
    issue(32'h28, "R10 held response data");
    e_hit++;
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(rsp_valid == 1'b1 && rsp_data == held, "R10 response held", rsp_data, held);
      check(req_ready == 1'b0, "R10 req_ready low while busy", req_ready, 0);
    end
    @(posedge clk);
    #1;
    rsp_ready = 1'b1;
    drain();

    // counter saturation
    for (int k = 0; k < 240; k++) begin
      read(32'h24, "R11 repeated hit data");
      e_hit++;
    end
    check(cnt_hit == CNT_W'(e_hit > CMAX ? CMAX : e_hit), "R11 hit counter saturates",
          cnt_hit, e_hit > CMAX ? CMAX : e_hit);
    check(cnt_miss == CNT_W'(e_miss), "R11 miss counter unaffected", cnt_miss, e_miss);
    check(cnt_sbhit == CNT_W'(e_sb), "R11 buffer counter unaffected", cnt_sbhit, e_sb);

    summary();
    $finish;
  end

endmodule